// File: doc/BRIEF.md
# Serial ADC Frame Controller

This block is the master side of a link to a low-power serial analog-to-digital converter that wakes itself at the start of every conversion and sleeps again at the end of it. On each frame it pulls the active-low select line down and waits a fixed setup delay with the serial clock held high. It then produces sixteen serial clock cycles at a run-time half period. It shifts in one data bit on each rising edge, most significant bit first, and lays the finished 16-bit word on a parallel bus with a one-cycle valid strobe. After that it releases the select line and holds the link idle until the programmed throughput period has run out.

The converter takes its sample at the third falling clock edge. The stretch from the select fall to that edge is the converter's power-up and acquisition window, and it must be provided again in every frame. The same period must also leave a minimum quiet gap after the select line rises. A combinational check watches the divider and period inputs and flags any pair that would cut either margin short. The controller refuses to begin a frame while that flag is up. A frame begins on a single start request, or keeps repeating for as long as the run enable is held.

All timing is counted in system-clock cycles. The setup delay, release delay, minimum quiet gap and minimum power-up window are parameters. The clock half period and the throughput period are inputs, and both are captured at the select fall.

Top module: `adc_frame_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, cs_n_o is 1, sclk_o is 1, busy_o is 0 and sample_vld_o is 0 until a frame is started.
- R2: When start_i or run_i is 1 in idle and cfg_err_o is 0, cs_n_o goes to 0 at the next clock edge. That cycle is cycle 0. sclk_o stays 1 for SETUP_CYC cycles, so its first fall is in cycle SETUP_CYC.
- R3: A frame has exactly 16 falling edges of sclk_o, and each level lasts H system cycles, where H is half_div_i as captured at the select fall. The third falling edge, which marks the end of the power-up window, is in cycle SETUP_CYC+4H.
- R4: sdata_i is sampled on each rising edge of sclk_o, first bit into bit 15. The full word appears on sample_o with sample_vld_o at 1 for exactly one cycle, in cycle SETUP_CYC+31H, which is the 16th rising edge. sample_vld_o is never 1 while cs_n_o is 1.
- R5: cs_n_o returns to 1 in cycle SETUP_CYC+31H+RELEASE_CYC. sclk_o is 1 in every cycle in which cs_n_o is 1.
- R6: busy_o is 1 from cycle 0 through cycle P-1, where P is period_i as captured at the select fall, and it is 1 whenever cs_n_o is 0. With run_i held, the next select fall comes exactly P cycles after the previous one.
- R7: cfg_err_o is 1 exactly when any of these holds: half_div_i is 0; SETUP_CYC+4*half_div_i is below PWR_MIN_CYC; period_i is below SETUP_CYC+31*half_div_i+RELEASE_CYC+QUIET_MIN.
- R8: While cfg_err_o is 1, start_i and run_i have no effect, and cs_n_o stays 1 in idle.
- R9: Changing half_div_i or period_i after the select fall has no effect on the frame in progress.
- R10: Asserting reset in the middle of a frame returns cs_n_o and sclk_o to 1 and busy_o to 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one frame |
| run_i | input | 1 | Repeat frames while high |
| half_div_i | input | DIV_W | Serial clock half period in system cycles |
| period_i | input | PER_W | Throughput period in system cycles |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low converter select |
| sclk_o | output | 1 | Serial clock to the converter, idles high |
| sample_o | output | NBITS | Last captured conversion word |
| sample_vld_o | output | 1 | One-cycle strobe with a new word |
| busy_o | output | 1 | Frame or quiet gap in progress |
| cfg_err_o | output | 1 | Divider and period settings violate a timing margin |

## Verification
The bench sets up configurations that sit on each side of every margin. A half period of 7 misses the power-up window and 8 just meets it. A period one cycle below the frame-plus-quiet minimum is rejected and the minimum itself is accepted. A design that got any of these sums wrong would accept a setting that starves the converter, or refuse one that is legal. Each frame is also timed edge by edge. The bench checks the third falling edge, the valid cycle, the select release and the end of busy. An off-by-one in a counter shows up as a shifted cycle number, and a wrong sampling edge shows up as a corrupted word from a converter model that changes its data on falling edges. Two more tests change the divider in the middle of a frame and assert reset in the middle of a frame. A controller that reads its inputs live would stretch the frame, and one with a stuck state would keep the select low.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_RELEASE,
        ST_QUIET
    } frame_state_e;
endpackage

// File: rtl/adc_cfg_check.sv
module adc_cfg_check #(
    parameter int DIV_W       = 8,
    parameter int PER_W       = 16,
    parameter int NBITS       = 16,
    parameter int SETUP_CYC   = 3,
    parameter int RELEASE_CYC = 2,
    parameter int QUIET_MIN   = 1,
    parameter int PWR_MIN_CYC = 32
) (
    input  logic [DIV_W-1:0] half_i,
    input  logic [PER_W-1:0] period_i,
    output logic             err_o
);
    localparam int CW = PER_W + DIV_W + 8;

    logic [CW-1:0] half_w;
    logic [CW-1:0] pwr_win;
    logic [CW-1:0] frame_min;

    always_comb begin
        half_w    = CW'(half_i);
        // setup delay plus two full clock periods before the hold edge
        pwr_win   = CW'(SETUP_CYC) + (half_w << 2);
        // cycles with select low, plus the quiet gap that must follow
        frame_min = CW'(SETUP_CYC) + CW'(2 * NBITS - 1) * half_w
                  + CW'(RELEASE_CYC) + CW'(QUIET_MIN);
        err_o     = (half_i == '0)
                  | (pwr_win < CW'(PWR_MIN_CYC))
                  | (CW'(period_i) < frame_min);
    end
endmodule

// File: rtl/adc_shift_in.sv
module adc_shift_in #(
    parameter int NBITS = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             shift_i,
    input  logic             last_i,
    input  logic             bit_i,
    output logic [NBITS-1:0] sample_o,
    output logic             vld_o
);
    logic [NBITS-1:0] sr_d, sr_q, res_d, res_q;
    logic             vld_d, vld_q;

    always_comb begin
        sr_d  = sr_q;
        res_d = res_q;
        vld_d = 1'b0;
        if (shift_i) begin
            sr_d = {sr_q[NBITS-2:0], bit_i};
            if (last_i) begin
                res_d = {sr_q[NBITS-2:0], bit_i};
                vld_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sr_q  <= '0;
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            sr_q  <= sr_d;
            res_q <= res_d;
            vld_q <= vld_d;
        end
    end

    assign sample_o = res_q;
    assign vld_o    = vld_q;
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
    import adc_frame_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int PER_W       = 16,
    parameter int NBITS       = 16,
    parameter int SETUP_CYC   = 3,
    parameter int RELEASE_CYC = 2,
    parameter int QUIET_MIN   = 1,
    parameter int PWR_MIN_CYC = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_div_i,
    input  logic [PER_W-1:0] period_i,
    input  logic             sdata_i,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic [NBITS-1:0] sample_o,
    output logic             sample_vld_o,
    output logic             busy_o,
    output logic             cfg_err_o
);
    localparam int BIT_W = $clog2(NBITS);

    typedef struct packed {
        frame_state_e     st;
        logic [DIV_W-1:0] cnt;
        logic [BIT_W-1:0] bits;
        logic [PER_W-1:0] pc;
        logic [DIV_W-1:0] half;
        logic [PER_W-1:0] per;
        logic             cs_n;
        logic             sclk;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  go;
    logic  shift_en;
    logic  last_bit;

    adc_cfg_check #(
        .DIV_W(DIV_W), .PER_W(PER_W), .NBITS(NBITS),
        .SETUP_CYC(SETUP_CYC), .RELEASE_CYC(RELEASE_CYC),
        .QUIET_MIN(QUIET_MIN), .PWR_MIN_CYC(PWR_MIN_CYC)
    ) cfg_i (
        .half_i  (half_div_i),
        .period_i(period_i),
        .err_o   (cfg_err_o)
    );

    adc_shift_in #(.NBITS(NBITS)) shf_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .shift_i (shift_en),
        .last_i  (last_bit),
        .bit_i   (sdata_i),
        .sample_o(sample_o),
        .vld_o   (sample_vld_o)
    );

    always_comb begin
        ctl_d    = ctl_q;
        shift_en = 1'b0;
        last_bit = 1'b0;
        go       = (start_i | run_i) & ~cfg_err_o;
        if (ctl_q.st != ST_IDLE) begin
            ctl_d.pc = ctl_q.pc + PER_W'(1);
        end
        unique case (ctl_q.st)
            ST_IDLE: begin
                ctl_d.cs_n = 1'b1;
                ctl_d.sclk = 1'b1;
                if (go) begin
                    ctl_d.st   = ST_SETUP;
                    ctl_d.cs_n = 1'b0;
                    ctl_d.cnt  = '0;
                    ctl_d.pc   = '0;
                    ctl_d.half = half_div_i;
                    ctl_d.per  = period_i;
                end
            end
            ST_SETUP: begin
                if (ctl_q.cnt == DIV_W'(SETUP_CYC - 1)) begin
                    ctl_d.st   = ST_SHIFT;
                    ctl_d.sclk = 1'b0;
                    ctl_d.cnt  = '0;
                    ctl_d.bits = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + DIV_W'(1);
                end
            end
            ST_SHIFT: begin
                if (ctl_q.cnt == ctl_q.half - DIV_W'(1)) begin
                    ctl_d.cnt  = '0;
                    ctl_d.sclk = ~ctl_q.sclk;
                    if (!ctl_q.sclk) begin
                        shift_en = 1'b1;
                        if (ctl_q.bits == BIT_W'(NBITS - 1)) begin
                            last_bit = 1'b1;
                            ctl_d.st = ST_RELEASE;
                        end else begin
                            ctl_d.bits = ctl_q.bits + BIT_W'(1);
                        end
                    end
                end else begin
                    ctl_d.cnt = ctl_q.cnt + DIV_W'(1);
                end
            end
            ST_RELEASE: begin
                if (ctl_q.cnt == DIV_W'(RELEASE_CYC - 1)) begin
                    ctl_d.st   = ST_QUIET;
                    ctl_d.cs_n = 1'b1;
                    ctl_d.cnt  = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + DIV_W'(1);
                end
            end
            ST_QUIET: begin
                if (ctl_q.pc == ctl_q.per - PER_W'(1)) begin
                    if (go) begin
                        ctl_d.st   = ST_SETUP;
                        ctl_d.cs_n = 1'b0;
                        ctl_d.cnt  = '0;
                        ctl_d.pc   = '0;
                        ctl_d.half = half_div_i;
                        ctl_d.per  = period_i;
                    end else begin
                        ctl_d.st = ST_IDLE;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_IDLE;
            ctl_q.cs_n <= 1'b1;
            ctl_q.sclk <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cs_n_o = ctl_q.cs_n;
    assign sclk_o = ctl_q.sclk;
    assign busy_o = (ctl_q.st != ST_IDLE);
endmodule

// File: rtl/adc_frame_ctrl_chk.sv
module adc_frame_ctrl_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic cs_n,
    input logic sclk,
    input logic busy,
    input logic vld,
    input logic cfg_err
);
    p_sclk_idle_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cs_n |-> sclk);

    p_vld_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld |=> !vld);

    p_vld_in_frame_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld |-> !cs_n);

    p_busy_covers_cs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cs_n |-> busy);

    p_blocked_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy && cfg_err) |=> cs_n);

    p_cs_fall_setup_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(cs_n) |-> sclk);
endmodule

bind adc_frame_ctrl adc_frame_ctrl_chk chk_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_n   (cs_n_o),
    .sclk   (sclk_o),
    .busy   (busy_o),
    .vld    (sample_vld_o),
    .cfg_err(cfg_err_o)
);

// File: tb/adc_frame_ctrl_tb_top.sv
module adc_frame_ctrl_tb_top;
    localparam int S  = 3;
    localparam int RL = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        run = 1'b0;
    logic [7:0]  half = 8'd8;
    logic [15:0] period = 16'd300;
    logic        sdata = 1'b0;
    logic        cs_n, sclk, vld, busy, cfg_err;
    logic [15:0] sample;
    logic [15:0] adc_word = 16'h0;
    int          idx = 0;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    adc_frame_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .run_i(run),
        .half_div_i(half), .period_i(period), .sdata_i(sdata),
        .cs_n_o(cs_n), .sclk_o(sclk), .sample_o(sample),
        .sample_vld_o(vld), .busy_o(busy), .cfg_err_o(cfg_err)
    );

    // converter model: new bit after each falling edge, MSB first
    always @(negedge sclk or posedge cs_n) begin
        if (cs_n) begin
            idx   = 0;
            sdata = 1'b0;
        end else begin
            sdata = adc_word[15 - idx];
            if (idx < 15) idx++;
        end
    end

    localparam int         VN = 5;
    localparam int         VH [VN] = '{8, 9, 12, 8, 10};
    localparam int         VP [VN] = '{254, 400, 500, 300, 320};
    localparam logic [15:0] VW [VN] = '{16'hA5C3, 16'h0001, 16'h8000, 16'hFFFF, 16'h3C96};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // called at a negedge; returns cycle numbers relative to the select fall
    task automatic run_frame(input int h, input int p, input logic [15:0] w, input int chg_at,
                             output int t_vld, output int t_csr, output int t_idle,
                             output int nfall, output int t_f3, output logic [15:0] cap);
        logic prev;
        half = 8'(h); period = 16'(p); adc_word = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t_vld = -1; t_csr = -1; t_idle = -1; nfall = 0; t_f3 = -1; cap = '0;
        prev = 1'b1;
        for (int t = 0; t < 3000; t++) begin
            if (t > 0) @(negedge clk);
            if (t == chg_at) begin half = 8'd3; period = 16'd20; end
            if (prev && !sclk) begin
                nfall++;
                if (nfall == 3) t_f3 = t;
            end
            prev = sclk;
            if (vld && t_vld < 0) begin t_vld = t; cap = sample; end
            if (cs_n && t_csr < 0) t_csr = t;
            if (!busy) begin t_idle = t; break; end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int t_vld, t_csr, t_idle, nfall, t_f3, tfall0, tfall1;
        logic [15:0] cap;
        bit   stay_high;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(cs_n === 1'b1 && sclk === 1'b1 && busy === 1'b0 && vld === 1'b0,
              "R1 reset outputs", {cs_n, sclk, busy, vld}, 4'b1100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(cs_n === 1'b1 && busy === 1'b0, "R1 idle after reset", {cs_n, busy}, 2'b10);

        // table of vectors
        for (int v = 0; v < VN; v++) begin
            run_frame(VH[v], VP[v], VW[v], -1, t_vld, t_csr, t_idle, nfall, t_f3, cap);
            check(t_f3 == S + 4 * VH[v], "R2 R3 third falling edge cycle", t_f3, S + 4 * VH[v]);
            check(nfall == 16, "R3 falling edge count", nfall, 16);
            check(t_vld == S + 31 * VH[v], "R4 valid cycle", t_vld, S + 31 * VH[v]);
            check(cap == VW[v], "R4 captured word", int'(cap), int'(VW[v]));
            check(t_csr == S + 31 * VH[v] + RL, "R5 select release cycle", t_csr, S + 31 * VH[v] + RL);
            check(t_idle == VP[v], "R6 busy length", t_idle, VP[v]);
        end

        // R7: margins
        half = 8'd7; period = 16'd400; #1;
        check(cfg_err === 1'b1, "R7 power-up window short", cfg_err, 1);
        half = 8'd8; period = 16'd253; #1;
        check(cfg_err === 1'b1, "R7 period one below minimum", cfg_err, 1);
        half = 8'd8; period = 16'd254; #1;
        check(cfg_err === 1'b0, "R7 period at minimum", cfg_err, 0);
        half = 8'd0; period = 16'd1000; #1;
        check(cfg_err === 1'b1, "R7 zero divider", cfg_err, 1);

        // R8: start ignored while the settings are rejected
        @(negedge clk);
        half = 8'd7; period = 16'd400; start = 1'b1; run = 1'b1;
        stay_high = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (cs_n !== 1'b1 || busy !== 1'b0) stay_high = 1'b0;
        end
        start = 1'b0; run = 1'b0;
        check(stay_high, "R8 blocked start keeps select high", stay_high, 1);

        // R9: divider and period changed mid-frame
        @(negedge clk);
        run_frame(8, 300, 16'h5A17, 60, t_vld, t_csr, t_idle, nfall, t_f3, cap);
        check(t_vld == S + 31 * 8, "R9 valid cycle unchanged", t_vld, S + 31 * 8);
        check(cap == 16'h5A17, "R9 word unchanged", int'(cap), int'(16'h5A17));
        check(t_idle == 300, "R9 period unchanged", t_idle, 300);

        // R6: continuous run spacing
        @(negedge clk);
        half = 8'd8; period = 16'd270; adc_word = 16'hC001; run = 1'b1;
        tfall0 = -1; tfall1 = -1;
        for (int t = 0; t < 1200; t++) begin
            @(negedge clk);
            if (!cs_n && tfall0 < 0) tfall0 = t;
            else if (tfall0 >= 0 && tfall1 < 0 && cs_n) tfall1 = -2;
            else if (tfall1 == -2 && !cs_n) begin tfall1 = t; break; end
        end
        check(tfall1 - tfall0 == 270, "R6 run-mode frame spacing", tfall1 - tfall0, 270);
        check(busy === 1'b1, "R6 busy held across frames", busy, 1);
        run = 1'b0;
        for (int t = 0; t < 600 && busy; t++) @(negedge clk);
        check(busy === 1'b0 && cs_n === 1'b1, "R6 idle after run drops", {busy, cs_n}, 2'b01);

        // R10: reset in mid-frame
        @(negedge clk);
        half = 8'd8; period = 16'd300; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (50) @(negedge clk);
        check(cs_n === 1'b0, "R10 frame in progress before reset", cs_n, 0);
        rst_n = 1'b0;
        #2;
        check(cs_n === 1'b1 && sclk === 1'b1 && busy === 1'b0, "R10 reset mid-frame",
              {cs_n, sclk, busy}, 3'b110);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(cs_n === 1'b1 && busy === 1'b0, "R10 idle after mid-frame reset", {cs_n, busy}, 2'b10);

        finish_run();
    end
endmodule